// File: doc/BRIEF.md
# Serial Receive Status Flag Controller

This block sits behind the bit-level front end of a serial receiver that runs either as an asynchronous UART or as a clock-synchronous port. The front end reports when a frame begins and when it ends. At the end it hands over the assembled byte, the received parity bit and the result of its stop-bit check. The controller keeps the receive buffer and maintains a set of sticky status flags: busy, finished, overrun, parity error, framing error and an error summary. It issues a receive-complete interrupt pulse and a DMA request pulse when a byte lands in the buffer.

Software drains the buffer by reading its lower byte, which the bus decoder reports as a one-cycle strobe. That read releases the finished and error flags, unless an overrun has occurred. An overrun freezes the buffer and the flags until the receiver is disabled. Dropping the enable input re-initialises every flag and aborts any frame in progress. The status byte keeps its bit layout because a register decoder elsewhere reads it directly.

Top module: `rx_flag_ctrl`

## Requirements
- R1: `stat_word` carries the flags at fixed bits. Bit 0 is always 0, bit 1 is busy, bit 2 is finished, bit 3 is the registered enable, bit 4 is overrun, bit 5 is parity error, bit 6 is framing error and bit 7 is the error summary. All bits are 0 after reset.
- R2: Busy is set one cycle after `frm_start`. It clears after `frm_done` (a start in the same cycle wins), and also clears after `rx_en` goes low.
- R3: An accepted frame writes `frm_data` into `buf_data`, sets finished and raises `irq_req` for one cycle. All of these become visible on the same clock edge.
- R4: While overrun is clear, `buf_rd_lo` clears finished, parity error and framing error.
- R5: If `frm_done` arrives while finished is set and no read happens in that cycle, overrun is set. The byte is discarded, and neither `irq_req` nor `dma_req` pulses.
- R6: While overrun is set, no frame reaches the buffer, `buf_rd_lo` clears nothing, and overrun stays set until `rx_en` is low.
- R7: When `rx_en` is low, busy, finished, overrun, parity error and framing error are all cleared on the next edge. The buffer contents are kept.
- R8: A parity error is flagged only when `uart_mode`=1 and `par_en`=1. The check counts the ones in the data byte and the parity bit together: an odd count is an error when `par_odd`=0, and an even count is an error when `par_odd`=1. In clock-synchronous mode (`uart_mode`=0), or with parity disabled, the parity flag is loaded as 0.
- R9: A frame with a parity error is still stored and still raises `irq_req`, but `dma_req` stays low. A clean frame pulses `dma_req` together with `irq_req`.
- R10: The framing flag is loaded from `frm_stop_bad` on an accepted frame in UART mode only. The error summary (bit 7) is the OR of overrun, parity error and framing error.
- R11: While `rx_en` is low, `frm_start`, `frm_done` and `buf_rd_lo` have no effect, and no request pulses.
- R12: A `buf_rd_lo` in the same cycle as `frm_done`, with finished set and overrun clear, frees the buffer. The new frame is then accepted rather than overrunning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low re-initialises the receiver |
| uart_mode | input | 1 | 1 = UART, 0 = clock-synchronous |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| frm_start | input | 1 | Strobe: a frame has started |
| frm_done | input | 1 | Strobe: a frame is complete |
| frm_data | input | DW | Assembled frame data |
| frm_par_bit | input | 1 | Received parity bit |
| frm_stop_bad | input | 1 | Stop-bit check failed |
| buf_rd_lo | input | 1 | Strobe: lower byte of the buffer was read |
| buf_data | output | DW | Receive buffer |
| stat_word | output | 8 | Status byte (layout in R1) |
| irq_req | output | 1 | Receive-complete interrupt pulse |
| dma_req | output | 1 | DMA transfer request pulse |

## Verification
The assertions watch the rules that hold on every cycle:
- the flags clear once enable drops;
- overrun is sticky and freezes the buffer, the finished flag and the interrupt;
- a DMA pulse only comes with an interrupt and never with a parity error;
- clock-synchronous frames never load a parity error.

Other behaviours depend on history or data values and only the bench's scenarios can show them:
- the exact data stored;
- the even and odd parity computation;
- read-and-complete in the same cycle;
- which of the error flags a read releases.

// File: rtl/rx_flag_pkg.sv
package rx_flag_pkg;

    localparam int STAT_W   = 8;
    localparam int B_BUSY   = 1;
    localparam int B_FIN    = 2;
    localparam int B_EN     = 3;
    localparam int B_OVR    = 4;
    localparam int B_PAR    = 5;
    localparam int B_FRM    = 6;
    localparam int B_ERR    = 7;

    typedef struct packed {
        logic en;
        logic fin;
        logic ovr;
        logic par;
        logic frm;
        logic irq;
        logic dma;
    } flag_s;

endpackage

// File: rtl/rx_parity_eval.sv
module rx_parity_eval #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          par_bit,
    input  logic          uart_mode,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          stop_bad,
    output logic          par_err,
    output logic          frm_err
);

    logic ones_odd;

    // total ones across data and parity bit; mismatch against selected sense
    always_comb begin
        ones_odd = par_bit;
        for (int i = 0; i < DW; i++) begin
            ones_odd = ones_odd ^ data[i];
        end
        par_err = uart_mode & par_en & (ones_odd != par_odd);
        frm_err = uart_mode & stop_bad;
    end

endmodule

// File: rtl/rx_busy_track.sv
module rx_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic done,
    output logic busy
);

    logic busy_d, busy_q;

    always_comb begin
        busy_d = busy_q;
        if (!en) begin
            busy_d = 1'b0;
        end else if (start) begin
            busy_d = 1'b1;
        end else if (done) begin
            busy_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else begin
            busy_q <= busy_d;
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/rx_flag_ctrl.sv
module rx_flag_ctrl
    import rx_flag_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              uart_mode,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              frm_start,
    input  logic              frm_done,
    input  logic [DW-1:0]     frm_data,
    input  logic              frm_par_bit,
    input  logic              frm_stop_bad,
    input  logic              buf_rd_lo,
    output logic [DW-1:0]     buf_data,
    output logic [STAT_W-1:0] stat_word,
    output logic              irq_req,
    output logic              dma_req
);

    flag_s         st_d, st_q;
    logic [DW-1:0] buf_d, buf_q;
    logic          busy;
    logic          par_err, frm_err;
    logic          rd_ok, take, spill;

    rx_parity_eval #(.DW(DW)) u_par (
        .data      (frm_data),
        .par_bit   (frm_par_bit),
        .uart_mode (uart_mode),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .stop_bad  (frm_stop_bad),
        .par_err   (par_err),
        .frm_err   (frm_err)
    );

    rx_busy_track u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .start (frm_start),
        .done  (frm_done),
        .busy  (busy)
    );

    always_comb begin
        st_d     = st_q;
        buf_d    = buf_q;
        st_d.en  = rx_en;
        st_d.irq = 1'b0;
        st_d.dma = 1'b0;
        // a read frees the buffer only when no overrun is latched
        rd_ok    = rx_en & buf_rd_lo & ~st_q.ovr;
        take     = rx_en & frm_done & ~st_q.ovr & (~st_q.fin | buf_rd_lo);
        spill    = rx_en & frm_done & ~take;
        if (!rx_en) begin
            st_d.fin = 1'b0;
            st_d.ovr = 1'b0;
            st_d.par = 1'b0;
            st_d.frm = 1'b0;
        end else begin
            if (rd_ok) begin
                st_d.fin = 1'b0;
                st_d.par = 1'b0;
                st_d.frm = 1'b0;
            end
            if (take) begin
                buf_d    = frm_data;
                st_d.fin = 1'b1;
                st_d.par = par_err;
                st_d.frm = frm_err;
                st_d.irq = 1'b1;
                st_d.dma = ~par_err;
            end
            if (spill) begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            buf_q <= '0;
        end else begin
            st_q  <= st_d;
            buf_q <= buf_d;
        end
    end

    always_comb begin
        stat_word         = '0;
        stat_word[B_BUSY] = busy;
        stat_word[B_FIN]  = st_q.fin;
        stat_word[B_EN]   = st_q.en;
        stat_word[B_OVR]  = st_q.ovr;
        stat_word[B_PAR]  = st_q.par;
        stat_word[B_FRM]  = st_q.frm;
        stat_word[B_ERR]  = st_q.ovr | st_q.par | st_q.frm;
    end

    assign buf_data = buf_q;
    assign irq_req  = st_q.irq;
    assign dma_req  = st_q.dma;

endmodule

// File: rtl/rx_flag_ctrl_chk.sv
module rx_flag_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          uart_mode,
    input logic          frm_done,
    input logic          buf_rd_lo,
    input logic [DW-1:0] buf_data,
    input logic [7:0]    stat_word,
    input logic          irq_req,
    input logic          dma_req
);

    AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !stat_word[1] && !stat_word[2] && !stat_word[4] && !stat_word[5] && !stat_word[6]); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && stat_word[4] |=> stat_word[4]); // R6

    AST_OVR_FREEZES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && stat_word[4] |=> $stable(buf_data) && !irq_req); // R6

    AST_OVR_KEEPS_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && stat_word[4] && stat_word[2] |=> stat_word[2]); // R6

    AST_IRQ_WITH_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> stat_word[2]); // R3

    AST_DMA_CLEAN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> irq_req && !stat_word[5]); // R9

    AST_CSIO_NO_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && !uart_mode && frm_done && !stat_word[4] && (!stat_word[2] || buf_rd_lo) |=> !stat_word[5]); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !irq_req && !dma_req); // R11

endmodule

bind rx_flag_ctrl rx_flag_ctrl_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .uart_mode (uart_mode),
    .frm_done  (frm_done),
    .buf_rd_lo (buf_rd_lo),
    .buf_data  (buf_data),
    .stat_word (stat_word),
    .irq_req   (irq_req),
    .dma_req   (dma_req)
);

// File: tb/rx_flag_ctrl_tb.sv
module rx_flag_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, uart_mode = 1'b1, par_en = 1'b1, par_odd = 1'b0;
    logic       frm_start = 1'b0, frm_done = 1'b0, frm_par_bit = 1'b0, frm_stop_bad = 1'b0;
    logic       buf_rd_lo = 1'b0;
    logic [7:0] frm_data = 8'h00;
    logic [7:0] buf_data, stat_word;
    logic       irq_req, dma_req;

    always #2.5 clk = ~clk;

    rx_flag_ctrl #(.DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .uart_mode(uart_mode),
        .par_en(par_en), .par_odd(par_odd), .frm_start(frm_start), .frm_done(frm_done),
        .frm_data(frm_data), .frm_par_bit(frm_par_bit), .frm_stop_bad(frm_stop_bad),
        .buf_rd_lo(buf_rd_lo), .buf_data(buf_data), .stat_word(stat_word),
        .irq_req(irq_req), .dma_req(dma_req)
    );

    // behavioural reference
    bit         m_busy, m_fin, m_ovr, m_par, m_frm, m_en, m_irq, m_dma, armed;
    logic [7:0] m_buf = 8'h00;
    int         vecs = 0, bad = 0, cycles = 0;
    string      cur_req = "R1";

    always @(posedge clk) begin
        armed = 1'b1;
        if (!rst_n) begin
            {m_busy, m_fin, m_ovr, m_par, m_frm, m_en, m_irq, m_dma} = '0;
            m_buf = 8'h00;
        end else begin
            bit free, pe;
            int ones;
            m_irq = 1'b0;
            m_dma = 1'b0;
            m_en  = rx_en;
            if (!rx_en) begin
                {m_busy, m_fin, m_ovr, m_par, m_frm} = '0;
            end else begin
                ones = int'(frm_par_bit);
                for (int i = 0; i < 8; i++) ones += int'(frm_data[i]);
                pe = uart_mode && par_en && ((ones % 2 == 1) != par_odd);
                free = !m_fin || buf_rd_lo;
                if (buf_rd_lo && !m_ovr) begin
                    m_fin = 1'b0; m_par = 1'b0; m_frm = 1'b0;
                end
                if (frm_done) begin
                    if (m_ovr || !free) begin
                        m_ovr = 1'b1;
                    end else begin
                        m_buf = frm_data; m_fin = 1'b1; m_irq = 1'b1;
                        m_par = pe; m_frm = uart_mode && frm_stop_bad; m_dma = !pe;
                    end
                end
                if (frm_start) m_busy = 1'b1;
                else if (frm_done) m_busy = 1'b0;
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog %s: actual cycles=%0d expected below 150000", cur_req, cycles);
            finish_run();
        end
        if (armed) begin
            logic [7:0] exp_word;
            exp_word = {m_ovr | m_par | m_frm, m_frm, m_par, m_ovr, m_en, m_fin, m_busy, 1'b0};
            vecs++;
            if (stat_word !== exp_word || buf_data !== m_buf || irq_req !== m_irq || dma_req !== m_dma) begin
                bad++;
                $display("FAIL %s: actual word=%b buf=%h irq=%b dma=%b expected word=%b buf=%h irq=%b dma=%b",
                         cur_req, stat_word, buf_data, irq_req, dma_req, exp_word, m_buf, m_irq, m_dma);
            end
        end
    end

    task automatic cyc(input bit s, input bit d, input logic [7:0] dat,
                       input bit pb, input bit sb, input bit rd);
        frm_start = s; frm_done = d; frm_data = dat;
        frm_par_bit = pb; frm_stop_bad = sb; buf_rd_lo = rd;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 0, 0);
    endtask

    task automatic rx_frame(input logic [7:0] dat, input bit pb, input bit sb);
        cyc(1, 0, 8'h00, 0, 0, 0);
        idle(2);
        cyc(0, 1, dat, pb, sb, 0);
        idle(1);
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; idle(2);
        rx_en = 1'b1; idle(2);

        // R2: busy through a frame, then abort by disabling
        cur_req = "R2"; rx_frame(8'h3C, 1'b0, 1'b0);
        cur_req = "R4"; cyc(0, 0, 8'h00, 0, 0, 1); idle(1);
        cur_req = "R2"; cyc(1, 0, 8'h00, 0, 0, 0); idle(1);
        rx_en = 1'b0; idle(1); rx_en = 1'b1; idle(1);

        // R3 and R8: even parity, good frame; R9 dma pulse with irq
        cur_req = "R3"; rx_frame(8'hA5, 1'b0, 1'b0);
        cur_req = "R4"; cyc(0, 0, 8'h00, 0, 0, 1); idle(1);

        // R9: odd sense, wrong parity bit -> stored, irq, no dma
        cur_req = "R9"; par_odd = 1'b1; rx_frame(8'h0F, 1'b0, 1'b0);
        cur_req = "R4"; cyc(0, 0, 8'h00, 0, 0, 1); idle(1);
        cur_req = "R8"; rx_frame(8'h0F, 1'b1, 1'b0);
        cyc(0, 0, 8'h00, 0, 0, 1);
        par_en = 1'b0; rx_frame(8'h01, 1'b1, 1'b0);
        cyc(0, 0, 8'h00, 0, 0, 1); par_en = 1'b1; par_odd = 1'b0;

        // R10: framing error in UART, ignored in CSIO
        cur_req = "R10"; rx_frame(8'h11, 1'b0, 1'b1);
        cyc(0, 0, 8'h00, 0, 0, 1);
        uart_mode = 1'b0; rx_frame(8'h13, 1'b0, 1'b1);
        cyc(0, 0, 8'h00, 0, 0, 1);
        cur_req = "R8"; rx_frame(8'h07, 1'b0, 1'b0);
        cyc(0, 0, 8'h00, 0, 0, 1); uart_mode = 1'b1;

        // R5 and R6: overrun, blocked read, sticky until disable
        cur_req = "R5"; par_odd = 1'b1; rx_frame(8'h22, 1'b0, 1'b0);
        rx_frame(8'h44, 1'b0, 1'b0);
        cur_req = "R6"; cyc(0, 0, 8'h00, 0, 0, 1); idle(1);
        cyc(0, 1, 8'h66, 0, 0, 1); idle(2);
        cur_req = "R7"; rx_en = 1'b0; idle(2);
        // R11: strobes with receiver disabled
        cur_req = "R11"; rx_frame(8'h99, 1'b0, 1'b1); cyc(0, 0, 8'h00, 0, 0, 1);
        rx_en = 1'b1; par_odd = 1'b0; idle(1);

        // R12: read and completion in the same cycle
        cur_req = "R12"; rx_frame(8'h5A, 1'b0, 1'b0);
        cyc(0, 1, 8'hC3, 1'b0, 1'b0, 1); idle(2);
        cyc(0, 0, 8'h00, 0, 0, 1); idle(1);

        // mixed traffic
        cur_req = "R6";
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rx_en = |lfsr[4:2];
            if (lfsr[11:9] == 3'b000) uart_mode = ~uart_mode;
            if (lfsr[14:12] == 3'b000) par_odd = ~par_odd;
            cyc(lfsr[0] & lfsr[5], lfsr[1] & lfsr[6], lfsr[15:8], lfsr[7], lfsr[3] & lfsr[8], lfsr[2] & lfsr[9]);
        end
        idle(2);
        finish_run();
    end

endmodule